// File: doc/BRIEF.md
# Fixed-Point Vector Lane ALU

One execution lane of a vector coprocessor. Every cycle it may accept one element pair, an opcode, a shift amount and a predicate bit. It produces a W-bit result two cycles later, together with a write-enable and an illegal-operation flag for the writeback stage. The operations are wrapping add and subtract, signed and unsigned saturating add and subtract, bitwise logic, and signed and unsigned fixed-point multiply. The multiply keeps the full product, shifts it right by the instruction's amount and then clamps it to the lane width.

The first pipeline stage computes a widened raw value from the adder, the multiplier or the logic unit. The second stage applies the right shift and the clamp that the opcode selects. A parameter mask decides which opcodes are built. An opcode that is masked out, or that is not defined, produces a zero result, raises the illegal flag and never writes. A clear predicate bit also blocks the write, so the destination element keeps its previous value.

Top module: `vec_lane_alu`

## Requirements
- R1: While rst_n is low, out_valid, out_we, out_illegal and out_result are all 0.
- R2: out_valid is high exactly two rising edges after a cycle in which in_valid is high, and low two edges after a cycle with in_valid low. When out_valid is low, out_result, out_we and out_illegal are 0.
- R3: Opcodes 0 (add) and 1 (subtract, a minus b) return the low W bits of the exact result, which wraps modulo 2^W.
- R4: Opcodes 2 (add) and 3 (subtract) treat the operands as two's-complement values and clamp the result to the range from -2^(W-1) to 2^(W-1)-1.
- R5: Opcodes 4 (add) and 5 (subtract) treat the operands as unsigned values and clamp the result to the range from 0 to 2^W-1. For example, a smaller minuend gives 0.
- R6: Opcodes 6, 7 and 8 return the bitwise AND, OR and XOR of the operands.
- R7: Opcode 9 forms the full 2W-bit signed product, shifts it right arithmetically by shamt, and clamps the result to the signed W-bit range.
- R8: Opcode 10 forms the full 2W-bit unsigned product, shifts it right by shamt, and clamps the result to 2^W-1.
- R9: A legal, valid operation with pred = 0 still presents its result, but holds out_we low. With pred = 1 and a legal opcode, out_we equals out_valid.
- R10: An opcode whose OP_EN bit is 0, and any opcode from 11 to 15, gives out_illegal = 1, out_we = 0 and out_result = 0 while out_valid is 1.
- R11: shamt has no effect on opcodes 0 to 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is presented this cycle |
| op | input | 4 | Opcode, encoded as listed in R3 to R10 |
| src_a | input | W | First element operand |
| src_b | input | W | Second element operand |
| shamt | input | $clog2(2W) | Right-shift amount for the multiply opcodes |
| pred | input | 1 | Element predicate; 0 blocks the write |
| out_valid | output | 1 | Result valid, two cycles after in_valid |
| out_result | output | W | Lane result |
| out_we | output | 1 | Write-enable for writeback |
| out_illegal | output | 1 | The opcode is disabled or undefined |

## Verification
The assertions check on every cycle that the valid signal has a two-cycle latency, that a clear predicate or an illegal flag in the first stage blocks the write at the output, that the multiplier shift amount is cleared for the non-multiply opcodes, and that an unsigned subtract with a smaller minuend gives zero. Only the bench's scenarios can show the arithmetic values: the wrap and clamp points in both signedness modes, the product scaling at shift amounts of zero and at the maximum, and the effect of the opcode mask. The mask is exercised by a second, 8-bit instance in which the XOR and unsigned-multiply opcodes are compiled out.

// File: rtl/vla_pkg.sv
package vla_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_ADDS = 4'd2,
        OP_SUBS = 4'd3,
        OP_ADDU = 4'd4,
        OP_SUBU = 4'd5,
        OP_AND  = 4'd6,
        OP_OR   = 4'd7,
        OP_XOR  = 4'd8,
        OP_MULS = 4'd9,
        OP_MULU = 4'd10
    } lane_op_e;

    localparam int NUM_OPS = 11;

    typedef enum logic [1:0] {
        CLAMP_NONE = 2'd0,
        CLAMP_S    = 2'd1,
        CLAMP_U    = 2'd2
    } clamp_e;

endpackage

// File: rtl/vla_exec.sv
module vla_exec
    import vla_pkg::*;
#(
    parameter int          W     = 32,
    parameter int          SHW   = $clog2(2 * W),
    parameter logic [15:0] OP_EN = 16'h07FF,
    localparam int         XW    = 2 * W + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [3:0]           op,
    input  logic [W-1:0]         src_a,
    input  logic [W-1:0]         src_b,
    input  logic [SHW-1:0]       shamt,
    input  logic                 pred,
    output logic                 s1_valid,
    output logic                 s1_illegal,
    output logic                 s1_pred,
    output clamp_e               s1_clamp,
    output logic [SHW-1:0]       s1_sh,
    output logic signed [XW-1:0] s1_raw
);

    localparam bit HAS_MUL = OP_EN[OP_MULS] | OP_EN[OP_MULU];

    typedef struct packed {
        logic                 valid;
        logic                 illegal;
        logic                 pred;
        clamp_e               clamp;
        logic [SHW-1:0]       sh;
        logic signed [XW-1:0] raw;
    } s1_t;

    s1_t s1_d, s1_q;

    logic [15:0]          op_legal;
    logic                 is_signed;
    logic signed [W:0]    ea, eb;
    logic signed [XW-1:0] ex, ey, sum_x, dif_x, prod_x;

    for (genvar g = 0; g < 16; g++) begin : g_legal
        if (g < NUM_OPS) begin : g_def
            assign op_legal[g] = OP_EN[g];
        end else begin : g_undef
            assign op_legal[g] = 1'b0;
        end
    end

    always_comb begin
        is_signed = (op == OP_ADDS) || (op == OP_SUBS) || (op == OP_MULS);
        ea        = $signed({is_signed & src_a[W-1], src_a});
        eb        = $signed({is_signed & src_b[W-1], src_b});
        ex        = {{(W+1){ea[W]}}, ea};
        ey        = {{(W+1){eb[W]}}, eb};
        sum_x     = ex + ey;
        dif_x     = ex - ey;
    end

    if (HAS_MUL) begin : g_mul
        assign prod_x = ex * ey;
    end else begin : g_nomul
        assign prod_x = '0;
    end

    always_comb begin
        s1_d = '0;
        if (in_valid) begin
            s1_d.valid = 1'b1;
            s1_d.pred  = pred;
            if (!op_legal[op]) begin
                s1_d.illegal = 1'b1;
            end else begin
                case (op)
                    OP_ADD:  begin s1_d.raw = sum_x; s1_d.clamp = CLAMP_NONE; end
                    OP_SUB:  begin s1_d.raw = dif_x; s1_d.clamp = CLAMP_NONE; end
                    OP_ADDS: begin s1_d.raw = sum_x; s1_d.clamp = CLAMP_S;    end
                    OP_SUBS: begin s1_d.raw = dif_x; s1_d.clamp = CLAMP_S;    end
                    OP_ADDU: begin s1_d.raw = sum_x; s1_d.clamp = CLAMP_U;    end
                    OP_SUBU: begin s1_d.raw = dif_x; s1_d.clamp = CLAMP_U;    end
                    OP_AND:  s1_d.raw = {{(W+2){1'b0}}, src_a & src_b};
                    OP_OR:   s1_d.raw = {{(W+2){1'b0}}, src_a | src_b};
                    OP_XOR:  s1_d.raw = {{(W+2){1'b0}}, src_a ^ src_b};
                    OP_MULS: begin
                        s1_d.raw   = prod_x;
                        s1_d.clamp = CLAMP_S;
                        s1_d.sh    = shamt;
                    end
                    OP_MULU: begin
                        s1_d.raw   = prod_x;
                        s1_d.clamp = CLAMP_U;
                        s1_d.sh    = shamt;
                    end
                    default: s1_d.illegal = 1'b1;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s1_q <= '0;
        else        s1_q <= s1_d;
    end

    assign s1_valid   = s1_q.valid;
    assign s1_illegal = s1_q.illegal;
    assign s1_pred    = s1_q.pred;
    assign s1_clamp   = s1_q.clamp;
    assign s1_sh      = s1_q.sh;
    assign s1_raw     = s1_q.raw;

    // R11: a non-multiply opcode never carries a shift into stage two
    assert_sh_cleared_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op != OP_MULS && op != OP_MULU) |=> (s1_q.sh == '0));

endmodule

// File: rtl/vla_satshift.sv
module vla_satshift
    import vla_pkg::*;
#(
    parameter int  W   = 32,
    parameter int  SHW = $clog2(2 * W),
    localparam int XW  = 2 * W + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 s1_valid,
    input  logic                 s1_illegal,
    input  logic                 s1_pred,
    input  clamp_e               s1_clamp,
    input  logic [SHW-1:0]       s1_sh,
    input  logic signed [XW-1:0] s1_raw,
    output logic                 out_valid,
    output logic [W-1:0]         out_result,
    output logic                 out_we,
    output logic                 out_illegal
);

    localparam logic signed [XW-1:0] S_MAX = {{(W+3){1'b0}}, {(W-1){1'b1}}};
    localparam logic signed [XW-1:0] S_MIN = {{(W+3){1'b1}}, {(W-1){1'b0}}};
    localparam logic signed [XW-1:0] U_MAX = {{(W+2){1'b0}}, {W{1'b1}}};

    typedef struct packed {
        logic         valid;
        logic         we;
        logic         illegal;
        logic [W-1:0] result;
    } out_t;

    out_t o_d, o_q;
    logic signed [XW-1:0] shifted;

    always_comb begin
        shifted   = s1_raw >>> s1_sh;
        o_d       = '0;
        o_d.valid = s1_valid;
        if (s1_valid && s1_illegal) begin
            o_d.illegal = 1'b1;
        end else if (s1_valid) begin
            o_d.we = s1_pred;
            case (s1_clamp)
                CLAMP_S: begin
                    if (shifted > S_MAX)      o_d.result = S_MAX[W-1:0];
                    else if (shifted < S_MIN) o_d.result = S_MIN[W-1:0];
                    else                      o_d.result = shifted[W-1:0];
                end
                CLAMP_U: begin
                    if (shifted > U_MAX)      o_d.result = U_MAX[W-1:0];
                    else if (shifted < 0)     o_d.result = '0;
                    else                      o_d.result = shifted[W-1:0];
                end
                default: o_d.result = shifted[W-1:0];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign out_valid   = o_q.valid;
    assign out_we      = o_q.we;
    assign out_illegal = o_q.illegal;
    assign out_result  = o_q.result;

    // R9: a cleared predicate in stage one blocks the write one edge later
    assert_pred_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_pred |=> !out_we);

    // R10: an illegal operation leaves a zero result and no write
    assert_illegal_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_illegal) |=> (out_illegal && !out_we && out_result == '0));

endmodule

// File: rtl/vec_lane_alu.sv
module vec_lane_alu
    import vla_pkg::*;
#(
    parameter int          W     = 32,
    parameter logic [15:0] OP_EN = 16'h07FF,
    localparam int         SHW   = $clog2(2 * W),
    localparam int         XW    = 2 * W + 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [3:0]     op,
    input  logic [W-1:0]   src_a,
    input  logic [W-1:0]   src_b,
    input  logic [SHW-1:0] shamt,
    input  logic           pred,
    output logic           out_valid,
    output logic [W-1:0]   out_result,
    output logic           out_we,
    output logic           out_illegal
);

    logic                 s1_valid, s1_illegal, s1_pred;
    clamp_e               s1_clamp;
    logic [SHW-1:0]       s1_sh;
    logic signed [XW-1:0] s1_raw;

    vla_exec #(.W(W), .SHW(SHW), .OP_EN(OP_EN)) u_exec (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .op         (op),
        .src_a      (src_a),
        .src_b      (src_b),
        .shamt      (shamt),
        .pred       (pred),
        .s1_valid   (s1_valid),
        .s1_illegal (s1_illegal),
        .s1_pred    (s1_pred),
        .s1_clamp   (s1_clamp),
        .s1_sh      (s1_sh),
        .s1_raw     (s1_raw)
    );

    vla_satshift #(.W(W), .SHW(SHW)) u_sat (
        .clk         (clk),
        .rst_n       (rst_n),
        .s1_valid    (s1_valid),
        .s1_illegal  (s1_illegal),
        .s1_pred     (s1_pred),
        .s1_clamp    (s1_clamp),
        .s1_sh       (s1_sh),
        .s1_raw      (s1_raw),
        .out_valid   (out_valid),
        .out_result  (out_result),
        .out_we      (out_we),
        .out_illegal (out_illegal)
    );

    // R2: valid appears two edges after it is presented
    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    // R2: an idle input slot gives an idle output slot
    assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);

    // R5: unsigned subtract below zero floors at zero
    assert_unsigned_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_SUBU && OP_EN[OP_SUBU] && src_a < src_b)
            |-> ##2 (out_result == '0));

endmodule

// File: tb/vec_lane_alu_tb.sv
module vec_lane_alu_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] NARROW_EN = 16'h02FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic [31:0] src_a = '0, src_b = '0;
    logic [5:0]  shamt = '0;
    logic        pred = 1'b0;

    logic        w_valid, w_we, w_ill;
    logic [31:0] w_res;
    logic        n_valid, n_we, n_ill;
    logic [7:0]  n_res;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vec_lane_alu #(.W(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .src_a(src_a), .src_b(src_b), .shamt(shamt), .pred(pred),
        .out_valid(w_valid), .out_result(w_res), .out_we(w_we), .out_illegal(w_ill)
    );

    // 8-bit lane with XOR (8) and unsigned multiply (10) compiled out
    vec_lane_alu #(.W(8), .OP_EN(NARROW_EN)) u_dut_narrow (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .src_a(src_a[7:0]), .src_b(src_b[7:0]), .shamt(shamt[3:0]), .pred(pred),
        .out_valid(n_valid), .out_result(n_res), .out_we(n_we), .out_illegal(n_ill)
    );

    typedef struct {
        logic        v;
        logic        we;
        logic        ill;
        logic [63:0] res;
        string       tag;
    } exp_t;

    exp_t wide_q[2];
    exp_t narrow_q[2];

    function automatic exp_t model(int w, logic [15:0] en, logic v, logic [3:0] op_i,
                                   logic [63:0] a, logic [63:0] b, logic [5:0] sh, logic p);
        exp_t e;
        logic signed [129:0] one, msk, ua, ub, sa, sb, x, smax, smin;
        int   shm;
        int   cl;
        logic legal;
        e.v = v; e.we = 1'b0; e.ill = 1'b0; e.res = '0; e.tag = "R2";
        if (!v) return e;
        legal = (op_i <= 4'd10) && en[op_i];
        if (!legal) begin
            e.ill = 1'b1; e.tag = "R10";
            return e;
        end
        one  = 130'sd1;
        msk  = (one <<< w) - one;
        ua   = {66'b0, a} & msk;
        ub   = {66'b0, b} & msk;
        sa   = ua[w-1] ? ua - (one <<< w) : ua;
        sb   = ub[w-1] ? ub - (one <<< w) : ub;
        smax = (one <<< (w - 1)) - one;
        smin = -(one <<< (w - 1));
        shm  = int'(sh) % (2 * w);
        cl   = 0;
        x    = '0;
        case (op_i)
            4'd0:  begin x = ua + ub; e.tag = "R3"; end
            4'd1:  begin x = ua - ub; e.tag = "R3"; end
            4'd2:  begin x = sa + sb; cl = 1; e.tag = "R4"; end
            4'd3:  begin x = sa - sb; cl = 1; e.tag = "R4"; end
            4'd4:  begin x = ua + ub; cl = 2; e.tag = "R5"; end
            4'd5:  begin x = ua - ub; cl = 2; e.tag = "R5"; end
            4'd6:  begin x = ua & ub; e.tag = "R6"; end
            4'd7:  begin x = ua | ub; e.tag = "R6"; end
            4'd8:  begin x = ua ^ ub; e.tag = "R6"; end
            4'd9:  begin x = (sa * sb) >>> shm; cl = 1; e.tag = "R7"; end
            default: begin x = (ua * ub) >>> shm; cl = 2; e.tag = "R8"; end
        endcase
        if (op_i <= 4'd8 && shm != 0) e.tag = "R11";
        if (cl == 1) begin
            if (x > smax) x = smax;
            else if (x < smin) x = smin;
        end else if (cl == 2) begin
            if (x > msk) x = msk;
            else if (x < 0) x = '0;
        end
        x     = x & msk;
        e.res = x[63:0];
        e.we  = p;
        if (!p) e.tag = "R9";
        return e;
    endfunction

    task automatic chk(string who, string tag, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", who, tag, act, expv);
        end
    endtask

    task automatic compare_outputs();
        chk("wide.valid",    "R2",             {63'b0, w_valid}, {63'b0, wide_q[1].v});
        chk("wide.we",       wide_q[1].tag,    {63'b0, w_we},    {63'b0, wide_q[1].we});
        chk("wide.illegal",  wide_q[1].tag,    {63'b0, w_ill},   {63'b0, wide_q[1].ill});
        chk("wide.result",   wide_q[1].tag,    {32'b0, w_res},   wide_q[1].res);
        chk("narrow.valid",  "R2",             {63'b0, n_valid}, {63'b0, narrow_q[1].v});
        chk("narrow.we",     narrow_q[1].tag,  {63'b0, n_we},    {63'b0, narrow_q[1].we});
        chk("narrow.illegal",narrow_q[1].tag,  {63'b0, n_ill},   {63'b0, narrow_q[1].ill});
        chk("narrow.result", narrow_q[1].tag,  {56'b0, n_res},   narrow_q[1].res);
    endtask

    task automatic step(logic v, logic [3:0] o, logic [31:0] a, logic [31:0] b,
                        logic [5:0] sh, logic p);
        @(negedge clk);
        compare_outputs();
        wide_q[1]   = wide_q[0];
        narrow_q[1] = narrow_q[0];
        wide_q[0]   = model(32, 16'h07FF, v, o, {32'b0, a}, {32'b0, b}, sh, p);
        narrow_q[0] = model(8, NARROW_EN, v, o, {32'b0, a}, {32'b0, b}, {2'b0, sh[3:0]}, p);
        in_valid = v; op = o; src_a = a; src_b = b; shamt = sh; pred = p;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R2: run did not finish, got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 2; i++) begin
            wide_q[i]   = model(32, 16'h07FF, 1'b0, '0, '0, '0, '0, 1'b0);
            narrow_q[i] = model(8, NARROW_EN, 1'b0, '0, '0, '0, '0, 1'b0);
        end
        // R1: outputs are quiet during reset, even with an operation presented
        in_valid = 1'b1; op = 4'd4; src_a = 32'hFFFF_FFFF; src_b = 32'h5; pred = 1'b1;
        repeat (3) @(negedge clk);
        chk("wide.reset",   "R1", {31'b0, w_valid, w_we, w_ill, w_res}, '0);
        chk("narrow.reset", "R1", {55'b0, n_valid, n_we, n_ill, n_res}, '0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // R3 wrap
        step(1, 4'd0, 32'hFFFF_FFFF, 32'h1, 0, 1);
        step(1, 4'd1, 32'h0, 32'h1, 0, 1);
        // R4 signed clamp at both ends
        step(1, 4'd2, 32'h7FFF_FFFF, 32'h1, 0, 1);
        step(1, 4'd3, 32'h8000_0000, 32'h1, 0, 1);
        step(1, 4'd2, 32'hFFFF_FFF0, 32'h5, 0, 1);
        // R5 unsigned clamp at both ends
        step(1, 4'd4, 32'hFFFF_FFFF, 32'h2, 0, 1);
        step(1, 4'd5, 32'h3, 32'h5, 0, 1);
        step(1, 4'd5, 32'h9, 32'h5, 0, 1);
        // R6 logic
        step(1, 4'd6, 32'hF0F0_1234, 32'hFF00_FF0F, 0, 1);
        step(1, 4'd7, 32'hF0F0_1234, 32'h0F00_0F0F, 0, 1);
        step(1, 4'd8, 32'hAAAA_5555, 32'hFFFF_0000, 0, 1);
        // R7 signed fixed-point multiply
        step(1, 4'd9, 32'h4000_0000, 32'h4000_0000, 6'd30, 1);
        step(1, 4'd9, 32'h4000_0000, 32'h4000_0000, 6'd0, 1);
        step(1, 4'd9, 32'hC000_0000, 32'h4000_0000, 6'd1, 1);
        step(1, 4'd9, 32'h8000_0000, 32'h8000_0000, 6'd63, 1);
        step(1, 4'd9, 32'hFFFF_FFFD, 32'h0000_0007, 6'd2, 1);
        // R8 unsigned fixed-point multiply
        step(1, 4'd10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 6'd32, 1);
        step(1, 4'd10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 6'd63, 1);
        step(1, 4'd10, 32'h0001_0000, 32'h0000_0100, 6'd4, 1);
        // R9 predicate off
        step(1, 4'd0, 32'h11, 32'h22, 0, 0);
        step(1, 4'd9, 32'h7, 32'h9, 6'd1, 0);
        // R10 undefined opcodes, and masked XOR/unsigned multiply on the narrow lane
        for (int k = 11; k < 16; k++) step(1, 4'(k), 32'h1234, 32'h5678, 0, 1);
        step(1, 4'd8, 32'h0F, 32'hFF, 0, 1);
        step(1, 4'd10, 32'h10, 32'h10, 6'd2, 1);
        // R11 shift amount on non-multiply opcodes
        step(1, 4'd0, 32'h100, 32'h23, 6'd5, 1);
        step(1, 4'd3, 32'h8000_0000, 32'h7, 6'd17, 1);
        step(1, 4'd6, 32'hFFFF, 32'hF0F0, 6'd63, 1);
        // R2 gaps in the input stream
        step(0, 4'd0, 32'h5, 32'h5, 0, 1);
        step(1, 4'd4, 32'h5, 32'h5, 0, 1);
        step(0, 4'd9, 32'h5, 32'h5, 0, 1);
        step(0, 4'd9, 32'h5, 32'h5, 0, 1);
        // mixed traffic over all opcodes
        for (int i = 0; i < 400; i++)
            step(($urandom % 5) != 0, 4'($urandom), $urandom, $urandom,
                 6'($urandom), ($urandom % 4) != 0);
        repeat (3) step(0, 4'd0, 0, 0, 0, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule